// File: doc/BRIEF.md
# I2C Slave Address Match Unit

This block decides whether an I2C slave answers a transfer. A separate bit-level front end samples the bus and hands over whole bytes. It also provides a one-cycle strobe for each START (or repeated START) and a one-cycle strobe for each received byte. The unit treats the first byte after a START as the address byte. It compares that byte against a primary 7-bit address, which can have a per-bit don't-care mask, and against three alternate 7-bit addresses that are enabled one by one. It reports whether there was a hit, which address was hit, the direction bit, and whether the byte was a general call. All of these stay unchanged until the next START.

As an option, the unit compares the first byte after a matched address against a programmed value and reports the result separately. Configuration is held in a small write-only register set. A write to the primary address is ignored while the slave is enabled, unless a general call was the last address seen.

Top module: `i2c_addr_match`

## Requirements
- R1: The address is bits [7:1] of the first byte strobed after a START, and bit 0 is the direction, shown on `rw_o` when the address matches (otherwise 0). All outputs are registered. They show the result on the cycle after the clock edge that captured the byte strobe.
- R2: The primary address matches when every bit where the mask holds 0 is equal. A mask bit of 1 makes that bit a don't-care. A mask of zero requires an exact match.
- R3: Each alternate address matches only on exact equality while its enable bit is 1. A disabled alternate never matches.
- R4: `match_idx_o` is 0 for the primary address and 1 to 3 for the alternates. When several addresses hit, the lowest index is reported.
- R5: An address byte of 0x00 sets `gcall_o` and never sets `match_o`.
- R6: A write to the primary address takes effect only while the slave-enable bit is 0 or while `gcall_o` is 1. At any other time it is ignored. The mask, alternates, data value and control register can always be written.
- R7: When data matching is enabled and the address matched, the next strobed byte sets `dmatch_vld_o` to 1 and `dmatch_o` to (byte == data value). Without an address match, `dmatch_vld_o` stays 0.
- R8: A START clears `match_o`, `match_idx_o`, `rw_o`, `gcall_o`, `dmatch_vld_o` and `dmatch_o` on the next cycle. Without a START these outputs hold their values.
- R9: A byte strobe that does not follow a START, and any byte after the address byte other than the data-match byte, is not treated as an address.
- R10: Reset clears every configuration field and every output. While the slave-enable bit is 0, no address byte produces a match or a general call.
- R11: If the START strobe and the byte strobe arrive in the same cycle, the START wins and that byte is dropped. The next strobed byte is the address.
- R12: Register select values are: 0 = control (bit 0 slave enable, bit 1 data-match enable, bits 2/3/4 enable alternates 1/2/3), 1 = primary address, 2 = mask, 3 = data value, 4/5/6 = alternates 1/2/3. Address values sit in the low 7 bits of the write data. A write takes effect on the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | 8 | Configuration write data |
| start_i | input | 1 | START / repeated START strobe from the front end |
| byte_vld_i | input | 1 | Received-byte strobe |
| byte_i | input | 8 | Received byte |
| match_o | output | 1 | Address matched |
| match_idx_o | output | 2 | Index of the matching address |
| rw_o | output | 1 | Direction bit of the matched address byte |
| gcall_o | output | 1 | General call received |
| dmatch_vld_o | output | 1 | Data-match result available |
| dmatch_o | output | 1 | First data byte equalled the programmed value |

## Verification
The assertions assume that the START and byte strobes are single-cycle pulses, and that configuration writes and bus bytes arrive only on clock cycles with reset released. The stimulus keeps to this by driving each strobe for exactly one clock period on the falling edge and dropping it on the next. The bench never holds the strobes across reset, and the one case with both strobes together is driven deliberately, to exercise the START-wins rule.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_DONE = 2'd3
    } am_state_e;

    localparam int SEL_CTRL = 0;
    localparam int SEL_PRIM = 1;
    localparam int SEL_MASK = 2;
    localparam int SEL_DVAL = 3;
    localparam int SEL_ALT0 = 4;

    localparam int CTRL_EN  = 0;
    localparam int CTRL_DM  = 1;
    localparam int CTRL_ALT = 2;

endpackage

// File: rtl/i2c_am_cfg.sv
module i2c_am_cfg
    import i2c_am_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int NUM_ALT = 3,
    localparam int BYTE_W = ADDR_W + 1,
    localparam int SEL_W  = $clog2(NUM_ALT + SEL_ALT0)
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              wr_i,
    input  logic [SEL_W-1:0]                  sel_i,
    input  logic [BYTE_W-1:0]                 wdata_i,
    input  logic                              gcall_i,
    output logic                              slave_en_o,
    output logic                              dmatch_en_o,
    output logic [NUM_ALT-1:0]                alt_en_o,
    output logic [ADDR_W-1:0]                 prim_o,
    output logic [ADDR_W-1:0]                 mask_o,
    output logic [NUM_ALT-1:0][ADDR_W-1:0]    alt_o,
    output logic [BYTE_W-1:0]                 dval_o
);

    typedef struct packed {
        logic                           slave_en;
        logic                           dmatch_en;
        logic [NUM_ALT-1:0]             alt_en;
        logic [ADDR_W-1:0]              prim;
        logic [ADDR_W-1:0]              mask;
        logic [NUM_ALT-1:0][ADDR_W-1:0] alt;
        logic [BYTE_W-1:0]              dval;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic prim_open;

    // Primary address may change only with the slave off or after a general call
    assign prim_open = !cfg_q.slave_en || gcall_i;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i) begin
            if (sel_i == SEL_W'(SEL_CTRL)) begin
                cfg_d.slave_en  = wdata_i[CTRL_EN];
                cfg_d.dmatch_en = wdata_i[CTRL_DM];
                cfg_d.alt_en    = wdata_i[CTRL_ALT +: NUM_ALT];
            end
            if (sel_i == SEL_W'(SEL_PRIM) && prim_open) begin
                cfg_d.prim = wdata_i[ADDR_W-1:0];
            end
            if (sel_i == SEL_W'(SEL_MASK)) begin
                cfg_d.mask = wdata_i[ADDR_W-1:0];
            end
            if (sel_i == SEL_W'(SEL_DVAL)) begin
                cfg_d.dval = wdata_i;
            end
            for (int i = 0; i < NUM_ALT; i++) begin
                if (sel_i == SEL_W'(SEL_ALT0 + i)) begin
                    cfg_d.alt[i] = wdata_i[ADDR_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign slave_en_o  = cfg_q.slave_en;
    assign dmatch_en_o = cfg_q.dmatch_en;
    assign alt_en_o    = cfg_q.alt_en;
    assign prim_o      = cfg_q.prim;
    assign mask_o      = cfg_q.mask;
    assign alt_o       = cfg_q.alt;
    assign dval_o      = cfg_q.dval;

    // R6: a locked write leaves the primary address untouched
    assert_prim_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && sel_i == SEL_W'(SEL_PRIM) && cfg_q.slave_en && !gcall_i)
        |=> $stable(prim_o));

    // R12: a control write lands on the next cycle
    assert_ctrl_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && sel_i == SEL_W'(SEL_CTRL))
        |=> slave_en_o == $past(wdata_i[CTRL_EN]));

endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp #(
    parameter int ADDR_W  = 7,
    parameter int NUM_ALT = 3,
    localparam int IDX_W  = $clog2(NUM_ALT + 1)
) (
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [ADDR_W-1:0]              prim_i,
    input  logic [ADDR_W-1:0]              mask_i,
    input  logic [NUM_ALT-1:0][ADDR_W-1:0] alt_i,
    input  logic [NUM_ALT-1:0]             alt_en_i,
    output logic                           hit_o,
    output logic [IDX_W-1:0]               idx_o
);

    logic [NUM_ALT:0] hits;

    // Slot 0: primary address with per-bit don't-care mask
    assign hits[0] = ((addr_i ^ prim_i) & ~mask_i) == '0;

    for (genvar g = 0; g < NUM_ALT; g++) begin : g_alt
        assign hits[g+1] = alt_en_i[g] && (addr_i == alt_i[g]);
    end

    // Lowest index wins: scan from the top so the last write is the lowest hit
    always_comb begin
        hit_o = |hits;
        idx_o = '0;
        for (int k = NUM_ALT; k >= 0; k--) begin
            if (hits[k]) begin
                idx_o = IDX_W'(k);
            end
        end
    end

    // R4: the reported slot hit and no lower slot did
    always_comb begin
        if (hit_o) begin
            assert_idx_is_hit_R4: assert (hits[idx_o]);
            for (int j = 0; j < NUM_ALT; j++) begin
                if (IDX_W'(j) < idx_o) begin
                    assert_idx_lowest_R4: assert (!hits[j]);
                end
            end
        end
    end

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int NUM_ALT = 3,
    localparam int BYTE_W = ADDR_W + 1,
    localparam int IDX_W  = $clog2(NUM_ALT + 1),
    localparam int SEL_W  = $clog2(NUM_ALT + SEL_ALT0)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_wr_i,
    input  logic [SEL_W-1:0]  cfg_sel_i,
    input  logic [BYTE_W-1:0] cfg_wdata_i,
    input  logic              start_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              match_o,
    output logic [IDX_W-1:0]  match_idx_o,
    output logic              rw_o,
    output logic              gcall_o,
    output logic              dmatch_vld_o,
    output logic              dmatch_o
);

    typedef struct packed {
        am_state_e        state;
        logic             match;
        logic [IDX_W-1:0] idx;
        logic             rw;
        logic             gcall;
        logic             dm_vld;
        logic             dm;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                           slave_en;
    logic                           dmatch_en;
    logic [NUM_ALT-1:0]             alt_en;
    logic [ADDR_W-1:0]              prim;
    logic [ADDR_W-1:0]              mask;
    logic [NUM_ALT-1:0][ADDR_W-1:0] alt;
    logic [BYTE_W-1:0]              dval;
    logic                           cmp_hit;
    logic [IDX_W-1:0]               cmp_idx;
    logic                           addr_take;
    logic [NUM_ALT:0]               slot_en;

    i2c_am_cfg #(
        .ADDR_W (ADDR_W),
        .NUM_ALT(NUM_ALT)
    ) cfg_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (cfg_wr_i),
        .sel_i      (cfg_sel_i),
        .wdata_i    (cfg_wdata_i),
        .gcall_i    (ctl_q.gcall),
        .slave_en_o (slave_en),
        .dmatch_en_o(dmatch_en),
        .alt_en_o   (alt_en),
        .prim_o     (prim),
        .mask_o     (mask),
        .alt_o      (alt),
        .dval_o     (dval)
    );

    i2c_am_cmp #(
        .ADDR_W (ADDR_W),
        .NUM_ALT(NUM_ALT)
    ) cmp_i (
        .addr_i  (byte_i[BYTE_W-1:1]),
        .prim_i  (prim),
        .mask_i  (mask),
        .alt_i   (alt),
        .alt_en_i(alt_en),
        .hit_o   (cmp_hit),
        .idx_o   (cmp_idx)
    );

    assign addr_take = byte_vld_i && !start_i && (ctl_q.state == ST_ADDR);
    assign slot_en   = {alt_en, 1'b1};

    always_comb begin
        ctl_d = ctl_q;
        if (start_i) begin
            // START wins over a byte in the same cycle
            ctl_d        = '0;
            ctl_d.state  = slave_en ? ST_ADDR : ST_IDLE;
        end else if (byte_vld_i) begin
            unique case (ctl_q.state)
                ST_ADDR: begin
                    ctl_d.state = ST_DONE;
                    if (byte_i == '0) begin
                        ctl_d.gcall = 1'b1;
                    end else if (cmp_hit) begin
                        ctl_d.match = 1'b1;
                        ctl_d.idx   = cmp_idx;
                        ctl_d.rw    = byte_i[0];
                        if (dmatch_en) begin
                            ctl_d.state = ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    ctl_d.state  = ST_DONE;
                    ctl_d.dm_vld = 1'b1;
                    ctl_d.dm     = (byte_i == dval);
                end
                default: begin
                    ctl_d.state = ctl_q.state;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign match_o      = ctl_q.match;
    assign match_idx_o  = ctl_q.idx;
    assign rw_o         = ctl_q.rw;
    assign gcall_o      = ctl_q.gcall;
    assign dmatch_vld_o = ctl_q.dm_vld;
    assign dmatch_o     = ctl_q.dm;

    assert_start_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (!match_o && !gcall_o && !dmatch_vld_o));

    assert_match_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match_o && !start_i) |=> (match_o && $stable(match_idx_o) && $stable(rw_o)));

    assert_gcall_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(gcall_o && match_o));

    assert_dm_needs_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dmatch_vld_o |-> match_o);

    assert_slot_enabled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_take && cmp_hit) |-> slot_en[cmp_idx]);

    assert_idle_no_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.state == ST_IDLE && !start_i) |=> (!match_o && !gcall_o));

endmodule

// File: tb/i2c_addr_match_tb_top.sv
module i2c_addr_match_tb_top;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       cfg_wr_i = 1'b0;
    logic [2:0] cfg_sel_i = '0;
    logic [7:0] cfg_wdata_i = '0;
    logic       start_i = 1'b0;
    logic       byte_vld_i = 1'b0;
    logic [7:0] byte_i = '0;
    logic       match_o;
    logic [1:0] match_idx_o;
    logic       rw_o;
    logic       gcall_o;
    logic       dmatch_vld_o;
    logic       dmatch_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk_i = ~clk_i;

    i2c_addr_match dut_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cfg_wr_i    (cfg_wr_i),
        .cfg_sel_i   (cfg_sel_i),
        .cfg_wdata_i (cfg_wdata_i),
        .start_i     (start_i),
        .byte_vld_i  (byte_vld_i),
        .byte_i      (byte_i),
        .match_o     (match_o),
        .match_idx_o (match_idx_o),
        .rw_o        (rw_o),
        .gcall_o     (gcall_o),
        .dmatch_vld_o(dmatch_vld_o),
        .dmatch_o    (dmatch_o)
    );

    // byte[12:5] | match[4] | idx[3:2] | rw[1] | gcall[0]
    localparam logic [12:0] VEC [8] = '{
        {8'hA0, 1'b1, 2'd0, 1'b0, 1'b0},
        {8'hA7, 1'b1, 2'd0, 1'b1, 1'b0},
        {8'hA8, 1'b0, 2'd0, 1'b0, 1'b0},
        {8'h44, 1'b1, 2'd1, 1'b0, 1'b0},
        {8'h42, 1'b0, 2'd0, 1'b0, 1'b0},
        {8'hA3, 1'b1, 2'd0, 1'b1, 1'b0},
        {8'h00, 1'b0, 2'd0, 1'b0, 1'b1},
        {8'h45, 1'b1, 2'd1, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_match(input string req, input int m, input int idx, input int rw);
        chk(req, "match", int'(match_o), m);
        if (m != 0) begin
            chk(req, "idx", int'(match_idx_o), idx);
            chk(req, "rw", int'(rw_o), rw);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [7:0] d);
        cfg_wr_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
        @(negedge clk_i);
        cfg_wr_i = 1'b0;
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        byte_vld_i = 1'b1; byte_i = b;
        @(negedge clk_i);
        byte_vld_i = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] b);
        pulse_start();
        send_byte(b);
    endtask

    task automatic do_reset();
        rst_ni = 1'b0;
        repeat (2) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
    endtask

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk_i);
        do_reset();
        // R10: reset state
        chk("R10", "match after reset", int'(match_o), 0);
        chk("R10", "gcall after reset", int'(gcall_o), 0);
        chk("R10", "dvld after reset", int'(dmatch_vld_o), 0);
        // R10: slave disabled, zero primary would otherwise hit 0x01
        xfer(8'h01);
        chk("R10", "disabled match", int'(match_o), 0);
        xfer(8'h00);
        chk("R10", "disabled gcall", int'(gcall_o), 0);

        // R12: configuration map
        cfg_write(3'd1, 8'h50);
        cfg_write(3'd2, 8'h03);
        cfg_write(3'd4, 8'h22);
        cfg_write(3'd5, 8'h21);
        cfg_write(3'd6, 8'h51);
        cfg_write(3'd0, 8'h15);

        // R9: byte with no START
        send_byte(8'hA0);
        chk("R9", "byte without start", int'(match_o), 0);

        // R1 R2 R3 R4 R5: table walk
        foreach (VEC[i]) begin
            xfer(VEC[i][12:5]);
            chk_match("R1", int'(VEC[i][4]), int'(VEC[i][3:2]), int'(VEC[i][1]));
            chk("R5", "gcall", int'(gcall_o), int'(VEC[i][0]));
        end

        // R3: enable alternate 2
        cfg_write(3'd0, 8'h1D);
        xfer(8'h42);
        chk_match("R3", 1, 2, 0);
        // R4: alternates 1 and 2 equal, lower wins
        cfg_write(3'd5, 8'h22);
        xfer(8'h44);
        chk_match("R4", 1, 1, 0);
        // R2: mask zero -> exact
        cfg_write(3'd2, 8'h00);
        xfer(8'hA2);
        chk_match("R2", 1, 3, 0);
        xfer(8'hA6);
        chk_match("R2", 0, 0, 0);

        // R8: hold then clear on START
        xfer(8'hA1);
        repeat (5) @(negedge clk_i);
        chk_match("R8", 1, 0, 1);
        pulse_start();
        chk("R8", "cleared by start", int'(match_o), 0);
        chk("R8", "rw cleared", int'(rw_o), 0);

        // R9: later byte is not an address
        xfer(8'hA0);
        send_byte(8'h44);
        chk_match("R9", 1, 0, 0);

        // R11: START and byte together
        start_i = 1'b1; byte_vld_i = 1'b1; byte_i = 8'hA0;
        @(negedge clk_i);
        start_i = 1'b0; byte_vld_i = 1'b0;
        chk("R11", "same-cycle byte dropped", int'(match_o), 0);
        send_byte(8'h44);
        chk_match("R11", 1, 1, 0);

        // R6: locked write ignored
        cfg_write(3'd1, 8'h10);
        xfer(8'hA0);
        chk_match("R6", 1, 0, 0);
        xfer(8'h20);
        chk_match("R6", 0, 0, 0);
        // R6: write allowed after general call
        xfer(8'h00);
        cfg_write(3'd1, 8'h10);
        xfer(8'h20);
        chk_match("R6", 1, 0, 0);
        xfer(8'hA0);
        chk_match("R6", 0, 0, 0);

        // R7: data match
        cfg_write(3'd3, 8'h5A);
        cfg_write(3'd0, 8'h1F);
        xfer(8'h20);
        chk("R7", "dvld before data", int'(dmatch_vld_o), 0);
        send_byte(8'h5A);
        chk("R7", "dvld equal", int'(dmatch_vld_o), 1);
        chk("R7", "dm equal", int'(dmatch_o), 1);
        xfer(8'h20);
        send_byte(8'h5B);
        chk("R7", "dvld differ", int'(dmatch_vld_o), 1);
        chk("R7", "dm differ", int'(dmatch_o), 0);
        xfer(8'h30);
        send_byte(8'h5A);
        chk("R7", "dvld no match", int'(dmatch_vld_o), 0);

        // R10: mid-run reset clears configuration
        do_reset();
        chk("R10", "match after reset 2", int'(match_o), 0);
        cfg_write(3'd0, 8'h01);
        xfer(8'h01);
        chk_match("R10", 1, 0, 1);
        xfer(8'h44);
        chk_match("R10", 0, 0, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule